// File: doc/BRIEF.md
# Frame Priority Classifier

This block gives every received frame a transmit queue number (one of four) and a drop level (one of two). An upstream parser supplies the header fields it has already extracted: the ingress port number, whether a VLAN tag is present together with its 3-bit priority, whether the frame is IPv4 together with its DS/TOS byte, and whether it carries TCP or UDP together with its 16-bit source and destination ports. The block registers one result per strobe. The result is valid on the cycle after `in_valid`.

Four sources can supply the class:
- the ingress port's default class;
- the VLAN priority, through an 8-entry table;
- the DS/TOS byte, through a 64-entry table;
- a layer-4 port match.

The layer-4 matcher checks eight entries with fixed port numbers, eight entries whose port numbers are written by software, and one inclusive port range. Each entry carries its own enable and its own class.

A control register sets the order in which the sources are tried. It also holds one enable bit for each of the three header-based sources. A per-port option replaces the VLAN-derived class with the port default. All tables and controls are written through a simple write port.

Top module: `frame_prio_classifier`

## Requirements
- R1: After synchronous reset, `out_valid`, `out_queue` and `out_drop` are 0. Every table and enable is 0 and the order register is 0x1B. A frame therefore receives its port default class, and that default is 0.
- R2: A strobe on `in_valid` produces `out_valid`=1 exactly one cycle later. In a cycle after no strobe, `out_valid` is 0 and `out_queue`/`out_drop` keep their last values.
- R3: A class value is 3 bits: bit 2 is the drop level and bits 1:0 are the queue. When the tag source is enabled (control bit 8) and a tag is present, that source supplies the tag table entry at address 0x00+tag priority. Without a tag, the tag source does not apply.
- R4: Each port default entry sits at address 0x80+port. Bits 2:0 hold the class and bit 3 is the override. When the override is set, a tagged frame on that port takes the port class from the tag source instead of the tag table entry.
- R5: When the DS/TOS source is enabled (control bit 9) and the frame is IPv4, that source supplies the TOS table entry at address 0x40+TOS[7:2].
- R6: Fixed entries 0..7 match the port numbers 21, 22, 23, 25, 53, 80, 110 and 443 in that order. Their classes sit at 0x18+i. An entry takes part only when its enable bit is set; the enable register is at 0x28 and bit i enables entry i.
- R7: Programmable entries 8..15 take their port number from 0x10+k and their class from 0x20+k, where k = entry−8. Each is enabled by bit 8+k of 0x28.
- R8: The range entry matches any port p with low ≤ p ≤ high, inclusive at both ends. The low bound is at 0x29 and the high bound at 0x2A. Register 0x2B holds the range class in bits 2:0 and the range enable in bit 3.
- R9: When the layer-4 source is enabled (control bit 10) and the frame is TCP/UDP, matching proceeds in a fixed order. The destination port is tried first, against entries 0..15 and then the range; the source port is tried only if the destination port finds nothing. Within one port, the lowest-numbered enabled matching entry wins and the range ranks last.
- R10: Control register 0x2C bits 7:0 hold four 2-bit slots, with slot 0 (bits 1:0) tried first. The codes are 0 = port default, 1 = tag, 2 = DS/TOS, 3 = layer-4. The first slot whose source applies supplies the class. Code 0 always applies.
- R11: When no slot names a source that applies, the frame gets its port default class.
- R12: A table write in the same cycle as a strobe does not affect that frame's result. It applies from the next strobe onward.
- R13: Writes to addresses outside the map have no effect on any later classification. The map covers 0x00-0x2C, 0x40-0x7F and 0x80+port for existing ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Frame header strobe |
| in_port | input | PORT_W | Ingress port number |
| in_vlan | input | 1 | VLAN tag present |
| in_tag_pri | input | 3 | VLAN tag priority |
| in_ipv4 | input | 1 | Frame is IPv4 |
| in_tos | input | 8 | DS/TOS byte |
| in_l4 | input | 1 | Frame is TCP or UDP |
| in_sport | input | 16 | Layer-4 source port |
| in_dport | input | 16 | Layer-4 destination port |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 8 | Configuration address |
| cfg_wdata | input | 16 | Configuration write data |
| out_valid | output | 1 | Result valid |
| out_queue | output | 2 | Transmit queue number |
| out_drop | output | 1 | Drop level |

## Verification
The hardest case to reach is a layered layer-4 conflict. In it, the destination and source ports hit different entries, a fixed and a programmable entry share one port number, or a port hits both an entry and the range. Each of these conflicts must also win or lose against tag and DS/TOS results under different orders. Directed stimulus builds each conflict: it programs overlapping entries and the range boundaries (low, high, one outside each) and then rewrites the order register. A long pseudo-random phase follows. It interleaves writes to every address, including unmapped ones, with frames whose ports are drawn mostly from the programmed values. A behavioural model is compared on every result.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    typedef struct packed {
        logic       drop;
        logic [1:0] queue;
    } cls_t;

    typedef enum logic [1:0] {
        SRC_PORT = 2'd0,
        SRC_TAG  = 2'd1,
        SRC_TOS  = 2'd2,
        SRC_L4   = 2'd3
    } src_e;

    localparam int FIXED_N = 8;
    localparam int PROG_N  = 8;
    localparam int ENT_N   = FIXED_N + PROG_N;
    localparam int TAG_N   = 8;
    localparam int TOS_N   = 64;
    localparam int CTRL_W  = 11;

    localparam logic [7:0] A_EN     = 8'h28;
    localparam logic [7:0] A_RLO    = 8'h29;
    localparam logic [7:0] A_RHI    = 8'h2A;
    localparam logic [7:0] A_RCTL   = 8'h2B;
    localparam logic [7:0] A_CTRL   = 8'h2C;
    localparam logic [CTRL_W-1:0] CTRL_RST = 11'h01B;

    function automatic logic [15:0] fixed_port(input int idx);
        case (idx)
            0:       return 16'd21;
            1:       return 16'd22;
            2:       return 16'd23;
            3:       return 16'd25;
            4:       return 16'd53;
            5:       return 16'd80;
            6:       return 16'd110;
            default: return 16'd443;
        endcase
    endfunction

endpackage

// File: rtl/fpc_cfg_regs.sv
module fpc_cfg_regs
    import fpc_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    localparam int PORT_W = $clog2(NUM_PORTS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [7:0]          cfg_addr,
    input  logic [15:0]         cfg_wdata,
    output cls_t                tag_tbl  [TAG_N],
    output cls_t                tos_tbl  [TOS_N],
    output logic [3:0]          pdef     [NUM_PORTS],
    output logic [15:0]         prog_num [PROG_N],
    output cls_t                cls_ent  [ENT_N],
    output logic [ENT_N-1:0]    ent_en,
    output logic [15:0]         rng_lo,
    output logic [15:0]         rng_hi,
    output logic [3:0]          rng_ctl,
    output logic [CTRL_W-1:0]   ctrl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TAG_N; i++)     tag_tbl[i]  <= '0;
            for (int i = 0; i < TOS_N; i++)     tos_tbl[i]  <= '0;
            for (int i = 0; i < NUM_PORTS; i++) pdef[i]     <= '0;
            for (int i = 0; i < PROG_N; i++)    prog_num[i] <= '0;
            for (int i = 0; i < ENT_N; i++)     cls_ent[i]  <= '0;
            ent_en  <= '0;
            rng_lo  <= '0;
            rng_hi  <= '0;
            rng_ctl <= '0;
            ctrl    <= CTRL_RST;
        end else if (cfg_we) begin
            if (cfg_addr[7:3] == 5'b00000)
                tag_tbl[cfg_addr[2:0]] <= cls_t'(cfg_wdata[2:0]);
            if (cfg_addr[7:6] == 2'b01)
                tos_tbl[cfg_addr[5:0]] <= cls_t'(cfg_wdata[2:0]);
            if (cfg_addr[7:3] == 5'b00010)
                prog_num[cfg_addr[2:0]] <= cfg_wdata;
            if (cfg_addr[7:3] == 5'b00011)
                cls_ent[{1'b0, cfg_addr[2:0]}] <= cls_t'(cfg_wdata[2:0]);
            if (cfg_addr[7:3] == 5'b00100)
                cls_ent[{1'b1, cfg_addr[2:0]}] <= cls_t'(cfg_wdata[2:0]);
            if (cfg_addr == A_EN)   ent_en  <= cfg_wdata;
            if (cfg_addr == A_RLO)  rng_lo  <= cfg_wdata;
            if (cfg_addr == A_RHI)  rng_hi  <= cfg_wdata;
            if (cfg_addr == A_RCTL) rng_ctl <= cfg_wdata[3:0];
            if (cfg_addr == A_CTRL) ctrl    <= cfg_wdata[CTRL_W-1:0];
            if (cfg_addr[7] && (cfg_addr[6:0] < 7'(NUM_PORTS)))
                pdef[cfg_addr[PORT_W-1:0]] <= cfg_wdata[3:0];
        end
    end

    // R10: a control write is visible on the following cycle
    a_r10_ctrl_write: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == A_CTRL) |=> (ctrl == $past(cfg_wdata[CTRL_W-1:0])));

endmodule

// File: rtl/fpc_l4_match.sv
module fpc_l4_match
    import fpc_pkg::*;
(
    input  logic [15:0]       dport,
    input  logic [15:0]       sport,
    input  logic [15:0]       prog_num [PROG_N],
    input  cls_t              cls_ent  [ENT_N],
    input  logic [ENT_N-1:0]  ent_en,
    input  logic [15:0]       rng_lo,
    input  logic [15:0]       rng_hi,
    input  logic [3:0]        rng_ctl,
    output logic              hit,
    output cls_t              hit_cls
);

    logic [15:0]      ent_num [ENT_N];
    logic [ENT_N-1:0] d_match, s_match;
    logic             d_rng, s_rng;
    cls_t             d_cls, s_cls;
    logic             d_hit, s_hit;

    for (genvar g = 0; g < ENT_N; g++) begin : g_ent
        if (g < FIXED_N) begin : g_fix
            assign ent_num[g] = fixed_port(g);
        end else begin : g_prog
            assign ent_num[g] = prog_num[g - FIXED_N];
        end
        assign d_match[g] = ent_en[g] && (ent_num[g] == dport);
        assign s_match[g] = ent_en[g] && (ent_num[g] == sport);
    end

    assign d_rng = rng_ctl[3] && (dport >= rng_lo) && (dport <= rng_hi);
    assign s_rng = rng_ctl[3] && (sport >= rng_lo) && (sport <= rng_hi);

    // lowest-numbered entry wins; range ranks after all entries
    always_comb begin
        d_hit = d_rng;
        d_cls = cls_t'(rng_ctl[2:0]);
        s_hit = s_rng;
        s_cls = cls_t'(rng_ctl[2:0]);
        for (int i = ENT_N - 1; i >= 0; i--) begin
            if (d_match[i]) begin
                d_hit = 1'b1;
                d_cls = cls_ent[i];
            end
            if (s_match[i]) begin
                s_hit = 1'b1;
                s_cls = cls_ent[i];
            end
        end
    end

    assign hit     = d_hit || s_hit;
    assign hit_cls = d_hit ? d_cls : s_cls;

endmodule

// File: rtl/fpc_select.sv
module fpc_select
    import fpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_vlan,
    input  logic              in_ipv4,
    input  logic              in_l4,
    input  logic [3:0]        port_def,
    input  cls_t              tag_cls,
    input  cls_t              tos_cls,
    input  logic              l4_hit,
    input  cls_t              l4_cls,
    input  logic [CTRL_W-1:0] ctrl,
    output logic              out_valid,
    output cls_t              out_cls
);

    logic [3:0] app;
    cls_t       cand [4];
    cls_t       port_cls;
    cls_t       win;
    logic       found;
    src_e       code;

    assign port_cls = cls_t'(port_def[2:0]);

    always_comb begin
        app[SRC_PORT]  = 1'b1;
        app[SRC_TAG]   = ctrl[8] && in_vlan;
        app[SRC_TOS]   = ctrl[9] && in_ipv4;
        app[SRC_L4]    = ctrl[10] && in_l4 && l4_hit;
        cand[SRC_PORT] = port_cls;
        cand[SRC_TAG]  = port_def[3] ? port_cls : tag_cls;
        cand[SRC_TOS]  = tos_cls;
        cand[SRC_L4]   = l4_cls;
    end

    always_comb begin
        win   = port_cls;
        found = 1'b0;
        code  = SRC_PORT;
        for (int s = 0; s < 4; s++) begin
            code = src_e'(ctrl[2*s +: 2]);
            if (!found && app[code]) begin
                win   = cand[code];
                found = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_cls   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_cls <= win;
        end
    end

    a_r2_strobe_result: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_cls)));

    a_r11_fallback: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !app[SRC_TAG] && !app[SRC_TOS] && !app[SRC_L4])
        |=> (out_cls == $past(port_cls)));

endmodule

// File: rtl/frame_prio_classifier.sv
module frame_prio_classifier
    import fpc_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    localparam int PORT_W = $clog2(NUM_PORTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [PORT_W-1:0] in_port,
    input  logic              in_vlan,
    input  logic [2:0]        in_tag_pri,
    input  logic              in_ipv4,
    input  logic [7:0]        in_tos,
    input  logic              in_l4,
    input  logic [15:0]       in_sport,
    input  logic [15:0]       in_dport,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [15:0]       cfg_wdata,
    output logic              out_valid,
    output logic [1:0]        out_queue,
    output logic              out_drop
);

    cls_t              tag_tbl  [TAG_N];
    cls_t              tos_tbl  [TOS_N];
    logic [3:0]        pdef     [NUM_PORTS];
    logic [15:0]       prog_num [PROG_N];
    cls_t              cls_ent  [ENT_N];
    logic [ENT_N-1:0]  ent_en;
    logic [15:0]       rng_lo, rng_hi;
    logic [3:0]        rng_ctl;
    logic [CTRL_W-1:0] ctrl;
    logic              l4_hit;
    cls_t              l4_cls;
    cls_t              out_cls;
    logic              unused_tos;

    assign unused_tos = ^in_tos[1:0];

    fpc_cfg_regs #(.NUM_PORTS(NUM_PORTS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .tag_tbl   (tag_tbl),
        .tos_tbl   (tos_tbl),
        .pdef      (pdef),
        .prog_num  (prog_num),
        .cls_ent   (cls_ent),
        .ent_en    (ent_en),
        .rng_lo    (rng_lo),
        .rng_hi    (rng_hi),
        .rng_ctl   (rng_ctl),
        .ctrl      (ctrl)
    );

    fpc_l4_match u_match (
        .dport    (in_dport),
        .sport    (in_sport),
        .prog_num (prog_num),
        .cls_ent  (cls_ent),
        .ent_en   (ent_en),
        .rng_lo   (rng_lo),
        .rng_hi   (rng_hi),
        .rng_ctl  (rng_ctl),
        .hit      (l4_hit),
        .hit_cls  (l4_cls)
    );

    fpc_select u_sel (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_vlan   (in_vlan),
        .in_ipv4   (in_ipv4),
        .in_l4     (in_l4),
        .port_def  (pdef[in_port]),
        .tag_cls   (tag_tbl[in_tag_pri]),
        .tos_cls   (tos_tbl[in_tos[7:2]]),
        .l4_hit    (l4_hit),
        .l4_cls    (l4_cls),
        .ctrl      (ctrl),
        .out_valid (out_valid),
        .out_cls   (out_cls)
    );

    assign out_queue = out_cls.queue;
    assign out_drop  = out_cls.drop;

endmodule

// File: tb/test_frame_prio_classifier.sv
module test_frame_prio_classifier;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  in_port;
    logic        in_vlan;
    logic [2:0]  in_tag_pri;
    logic        in_ipv4;
    logic [7:0]  in_tos;
    logic        in_l4;
    logic [15:0] in_sport, in_dport;
    logic        cfg_we;
    logic [7:0]  cfg_addr;
    logic [15:0] cfg_wdata;
    logic        out_valid;
    logic [1:0]  out_queue;
    logic        out_drop;

    int errors = 0;
    int checks = 0;
    int last_exp = 0;
    bit finished = 0;

    // behavioural model state
    int m_tag [8];
    int m_tos [64];
    int m_pdef [NP];
    int m_prog [8];
    int m_cls [16];
    int m_en, m_lo, m_hi, m_rc, m_ctrl;
    int fixed_l [8] = '{21, 22, 23, 25, 53, 80, 110, 443};

    always #(CLK_PERIOD / 2) clk = ~clk;

    frame_prio_classifier #(.NUM_PORTS(NP)) i_frame_prio_classifier (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_port(in_port),
        .in_vlan(in_vlan), .in_tag_pri(in_tag_pri), .in_ipv4(in_ipv4),
        .in_tos(in_tos), .in_l4(in_l4), .in_sport(in_sport), .in_dport(in_dport),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .out_valid(out_valid), .out_queue(out_queue), .out_drop(out_drop)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void model_reset();
        foreach (m_tag[i])  m_tag[i] = 0;
        foreach (m_tos[i])  m_tos[i] = 0;
        foreach (m_pdef[i]) m_pdef[i] = 0;
        foreach (m_prog[i]) m_prog[i] = 0;
        foreach (m_cls[i])  m_cls[i] = 0;
        m_en = 0; m_lo = 0; m_hi = 0; m_rc = 0; m_ctrl = 'h1B;
    endfunction

    function automatic void model_write(input int a, input int d);
        if (a < 8)                   m_tag[a] = d & 7;
        else if (a >= 'h10 && a < 'h18) m_prog[a - 'h10] = d & 'hFFFF;
        else if (a >= 'h18 && a < 'h20) m_cls[a - 'h18] = d & 7;
        else if (a >= 'h20 && a < 'h28) m_cls[a - 'h20 + 8] = d & 7;
        else if (a == 'h28) m_en = d & 'hFFFF;
        else if (a == 'h29) m_lo = d & 'hFFFF;
        else if (a == 'h2A) m_hi = d & 'hFFFF;
        else if (a == 'h2B) m_rc = d & 'hF;
        else if (a == 'h2C) m_ctrl = d & 'h7FF;
        else if (a >= 'h40 && a < 'h80) m_tos[a - 'h40] = d & 7;
        else if (a >= 'h80 && a < 'h80 + NP) m_pdef[a - 'h80] = d & 'hF;
    endfunction

    function automatic int lookup(input int p);
        for (int i = 0; i < 16; i++) begin
            int num = (i < 8) ? fixed_l[i] : m_prog[i - 8];
            if (((m_en >> i) & 1) && num == p) return m_cls[i];
        end
        if (((m_rc >> 3) & 1) && p >= m_lo && p <= m_hi) return m_rc & 7;
        return -1;
    endfunction

    function automatic int model(input int port, input int vp, input int tag,
                                 input int ip, input int tos, input int l4,
                                 input int sp, input int dp);
        int pcls = m_pdef[port] & 7;
        int ovr  = (m_pdef[port] >> 3) & 1;
        int l4c  = lookup(dp);
        if (l4c < 0) l4c = lookup(sp);
        for (int s = 0; s < 4; s++) begin
            int code = (m_ctrl >> (2 * s)) & 3;
            if (code == 0) return pcls;
            if (code == 1 && ((m_ctrl >> 8) & 1) && vp) return ovr ? pcls : m_tag[tag];
            if (code == 2 && ((m_ctrl >> 9) & 1) && ip) return m_tos[tos >> 2];
            if (code == 3 && ((m_ctrl >> 10) & 1) && l4 && l4c >= 0) return l4c;
        end
        return pcls;
    endfunction

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = 8'(a); cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we = 0;
        model_write(a, d);
        chk(out_valid == 0 && {out_drop, out_queue} == 3'(last_exp), "R2 idle/hold",
            {out_valid, out_drop, out_queue}, last_exp);
    endtask

    task automatic classify(input int port, input int vp, input int tag, input int ip,
                            input int tos, input int l4, input int sp, input int dp,
                            input string req, input bit with_wr = 0,
                            input int wa = 0, input int wd = 0);
        int exp;
        @(negedge clk);
        in_valid = 1; in_port = 3'(port); in_vlan = vp[0]; in_tag_pri = 3'(tag);
        in_ipv4 = ip[0]; in_tos = 8'(tos); in_l4 = l4[0];
        in_sport = 16'(sp); in_dport = 16'(dp);
        exp = model(port, vp, tag, ip, tos, l4, sp, dp);
        if (with_wr) begin
            cfg_we = 1; cfg_addr = 8'(wa); cfg_wdata = 16'(wd);
        end
        @(negedge clk);
        in_valid = 0;
        if (with_wr) begin
            cfg_we = 0;
            model_write(wa, wd);
        end
        chk(out_valid == 1, "R2 valid", out_valid, 1);
        chk({out_drop, out_queue} == 3'(exp), req, {out_drop, out_queue}, exp);
        last_exp = exp;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1; in_valid = 0; in_port = 0; in_vlan = 0; in_tag_pri = 0; in_ipv4 = 0;
        in_tos = 0; in_l4 = 0; in_sport = 0; in_dport = 0;
        cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        chk(out_valid == 0 && out_queue == 0 && out_drop == 0, "R1 reset outputs",
            {out_valid, out_drop, out_queue}, 0);
        classify(2, 1, 5, 1, 'hB8, 1, 80, 80, "R1 reset default class");

        // R11: nothing enabled -> port default
        wr('h83, 6);
        classify(3, 1, 5, 1, 'hB8, 1, 80, 80, "R11 port default");

        // R3 tag source
        wr('h2C, 'h11B);
        wr('h05, 3);
        classify(0, 1, 5, 0, 0, 0, 0, 0, "R3 tag table");
        classify(3, 0, 5, 0, 0, 0, 0, 0, "R3 no tag falls to default");
        // R4 override
        wr('h83, 'hE);
        classify(3, 1, 5, 0, 0, 0, 0, 0, "R4 port override");

        // R5 DS/TOS
        wr('h2C, 'h31B);
        wr('h40 + 46, 5);
        classify(0, 1, 5, 1, 'hB8, 0, 0, 0, "R5 tos over tag by default order");
        classify(0, 0, 0, 1, 'hBB, 0, 0, 0, "R5 tos low bits ignored");

        // R6 fixed entries
        wr('h2C, 'h71B);
        wr('h18 + 5, 2);
        wr('h28, 'h0020);
        classify(0, 1, 5, 1, 'hB8, 1, 7, 80, "R6 fixed port 80");
        wr('h18 + 0, 7);
        classify(0, 1, 5, 1, 'hB8, 1, 7, 21, "R6 disabled entry ignored");
        wr('h28, 'h0021);
        classify(0, 1, 5, 1, 'hB8, 1, 7, 21, "R6 fixed port 21 enabled");

        // R7 programmable
        wr('h12, 5000);
        wr('h22, 7);
        wr('h28, 'h0420);
        classify(0, 0, 0, 0, 0, 1, 5000, 9, "R7 programmable on source");
        classify(0, 0, 0, 0, 0, 1, 9, 5000, "R7 programmable on destination");

        // R9 ordering
        classify(0, 0, 0, 0, 0, 1, 5000, 80, "R9 destination first");
        wr('h10, 80);
        wr('h20, 1);
        wr('h28, 'h0520);
        classify(0, 0, 0, 0, 0, 1, 0, 80, "R9 lowest entry wins");

        // R8 range
        wr('h29, 1000);
        wr('h2A, 2000);
        wr('h2B, 'hC);
        classify(0, 0, 0, 1, 'hB8, 1, 0, 1000, "R8 range low bound");
        classify(0, 0, 0, 1, 'hB8, 1, 0, 2000, "R8 range high bound");
        classify(0, 0, 0, 1, 'hB8, 1, 0, 2001, "R8 above range");
        classify(0, 0, 0, 1, 'hB8, 1, 0, 999, "R8 below range");
        wr('h11, 1500);
        wr('h21, 1);
        wr('h28, 'h0720);
        classify(0, 0, 0, 0, 0, 1, 0, 1500, "R9 entry beats range");
        classify(0, 0, 0, 0, 0, 1, 80, 1200, "R9 destination range beats source entry");

        // R10 order changes
        wr('h2C, 'h72D);
        classify(3, 1, 5, 1, 'hB8, 1, 0, 80, "R10 tag first with override");
        classify(0, 1, 5, 1, 'hB8, 1, 0, 80, "R10 tag first");
        classify(0, 0, 5, 1, 'hB8, 1, 0, 80, "R10 next slot l4");
        wr('h2C, 'h700);
        classify(3, 1, 5, 1, 'hB8, 1, 0, 80, "R10 port slot first");

        // R12 write same cycle as strobe
        wr('h2C, 'h72D);
        classify(0, 1, 5, 0, 0, 0, 0, 0, "R12 old value used", 1, 'h05, 0);
        classify(0, 1, 5, 0, 0, 0, 0, 0, "R12 new value after");

        // R13 unmapped writes
        wr('h30, 'hFFFF);
        wr('h88, 'hF);
        wr('h2D, 'h0);
        classify(0, 1, 4, 1, 'h10, 1, 80, 1500, "R13 unmapped write no effect");

        // pseudo-random mix
        for (int n = 0; n < 600; n++) begin
            int pick = $urandom_range(0, 3);
            if (pick == 0) begin
                int a = $urandom_range(0, 255);
                int d = $urandom_range(0, 65535);
                if (a == 'h29 || a == 'h2A) d = $urandom_range(0, 3000);
                if (a >= 'h10 && a < 'h18) d = $urandom_range(0, 3000);
                wr(a, d);
            end else begin
                int ports [6] = '{80, 21, 443, 1500, 5000, 0};
                int dp = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 3000)
                                                     : ports[$urandom_range(0, 5)];
                int sp = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 3000)
                                                     : ports[$urandom_range(0, 5)];
                classify($urandom_range(0, NP - 1), $urandom_range(0, 1),
                         $urandom_range(0, 7), $urandom_range(0, 1),
                         $urandom_range(0, 255), $urandom_range(0, 1), sp, dp,
                         "R10 random mix");
            end
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule